// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a 64-bit signed running total and adds a signed product to it each time a new operation is launched. The total is held as two 32-bit halves, a high half and a low half. Read together as `{accHi, accLo}`, they form one two's-complement value. Two product widths are offered. In long mode the full 32-bit operands are multiplied. In word mode only the low 16 bits of each operand are used. A saturation enable sampled with each operation selects a limiting rule, and the rule differs between the two modes.

An operation is launched by pulsing `start` while the unit is idle. The operands are multiplied into a product register on the launch edge. The total is updated on the following edge, and `done` pulses for one cycle after that. Any `start` seen before the `done` cycle is dropped. A `clear` pulse zeroes the total on the next edge at any time. If it lands on the same edge as an update, the clear wins.

Top module: `mac_sat_unit`

## Requirements
- R1: While reset is held low and on the first cycle after it is released, `accHi`, `accLo` and `done` are all zero.
- R2: In long mode (`wordMode`=0) with `satEn`=0, both operands are taken as signed 32-bit values and their 64-bit product is added to `{accHi,accLo}`, with wrap-around modulo 2^64.
- R3: In word mode (`wordMode`=1), bits 15:0 of each operand are sign-extended and multiplied, and operand bits 31:16 have no effect on the result. With `satEn`=0 the full 64-bit sum is written back.
- R4: In long mode with `satEn`=1, when the 64-bit sum is negative, bits 31:16 of `accHi` are forced to one. All other bits come from the sum.
- R5: In long mode with `satEn`=1, when the 64-bit sum is zero or positive, `accHi` keeps only bits 14:0 of the sum's high half, and bits 31:15 become zero. `accLo` comes from the sum.
- R6: In word mode with `satEn`=1, a sum below -2^31 writes `accHi`=1 and `accLo`=0x80000000.
- R7: In word mode with `satEn`=1, a sum above 2^31-1 writes `accHi`=1 and `accLo`=0x7FFFFFFF.
- R8: In word mode with `satEn`=1, a sum in the range [-2^31, 2^31-1] is written back unchanged as a 64-bit value.
- R9: `clear` high at a rising edge makes both halves zero from that edge on, even when an update falls on the same edge.
- R10: A `start` accepted at edge E0 changes the halves at edge E0+1 (not at E0), and `done` is high for exactly the one cycle after edge E0+2.
- R11: A `start` held or pulsed at edges E0+1 and E0+2 of an accepted operation is ignored: no second update happens and no second `done` follows. While no operation is in flight and `clear` is low, the halves stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opA | input | 32 | First multiplicand |
| opB | input | 32 | Second multiplicand |
| wordMode | input | 1 | 1 selects the 16x16 product, 0 the 32x32 product |
| satEn | input | 1 | Saturation enable for this operation |
| start | input | 1 | Launch strobe, taken only when idle |
| clear | input | 1 | Zero the total, overrides an update on the same edge |
| accHi | output | 32 | High half of the running total |
| accLo | output | 32 | Low half of the running total |
| done | output | 1 | One-cycle pulse after the total was updated |

## Verification
A wrong mode or saturation flag latched in the product stage shows up at the ports on the very next edge, as a wrong high half: a missing mask, a missing clamp or a missing 1. Each operation's result is compared one cycle after the update. A corrupted sequencing state shows as `done` arriving a cycle early or late, as a doubled update from a start that should have been dropped, or as a clear that a same-edge update overwrites. Each of these is visible within three edges of the launch. A stale value in the total carries into every later comparison against the running reference, so a single bad write is reported on the next operation at the latest.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_FIN  = 2'd2
  } mac_state_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;   // load product register
    logic accum;     // write total from product
    logic zeroAcc;   // force total to zero
  } mac_strobe_t;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        clear,
  output mac_strobe_t strb,
  output logic        busy,
  output logic        done
);

  mac_state_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (start) stateNext = ST_MUL;
      ST_MUL:  stateNext = ST_FIN;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_FIN);
    end
  end

  always_comb begin
    strb.capture = (state == ST_IDLE) && start;
    strb.accum   = (state == ST_MUL);
    strb.zeroAcc = clear;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int WORD_W = 16,
  parameter int LSAT_W = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  mac_strobe_t       strb,
  input  logic [HALF_W-1:0] opA,
  input  logic [HALF_W-1:0] opB,
  input  logic              wordMode,
  input  logic              satEn,
  output logic [HALF_W-1:0] accHi,
  output logic [HALF_W-1:0] accLo
);

  localparam int ACC_W = 2 * HALF_W;
  // long-mode masks on the high half
  localparam logic [HALF_W-1:0] HI_ONES = {HALF_W{1'b1}} << (LSAT_W - HALF_W);
  localparam logic [HALF_W-1:0] HI_KEEP = {HALF_W{1'b1}} >> (ACC_W - LSAT_W + 1);
  // word-mode clamp values
  localparam logic [HALF_W-1:0] W_HI  = HALF_W'(1);
  localparam logic [HALF_W-1:0] W_MIN = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [HALF_W-1:0] W_MAX = {1'b0, {(HALF_W-1){1'b1}}};
  localparam int TOP_W = ACC_W - HALF_W + 1;

  logic signed [ACC_W-1:0] extA, extB, prodNext, prodQ;
  logic                    wordQ, satQ;
  logic        [ACC_W-1:0] sumVal;
  logic        [ACC_W-1:0] resVal;
  logic        [HALF_W-1:0] sumHi, sumLo;
  logic                    sumNeg, overMax, underMin;

  // operand extension
  always_comb begin
    if (wordMode) begin
      extA = {{(ACC_W-WORD_W){opA[WORD_W-1]}}, opA[WORD_W-1:0]};
      extB = {{(ACC_W-WORD_W){opB[WORD_W-1]}}, opB[WORD_W-1:0]};
    end else begin
      extA = {{(ACC_W-HALF_W){opA[HALF_W-1]}}, opA};
      extB = {{(ACC_W-HALF_W){opB[HALF_W-1]}}, opB};
    end
    prodNext = extA * extB;
  end

  // product stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodQ <= '0;
      wordQ <= 1'b0;
      satQ  <= 1'b0;
    end else if (strb.capture) begin
      prodQ <= prodNext;
      wordQ <= wordMode;
      satQ  <= satEn;
    end
  end

  // sum and write-back rule
  always_comb begin
    sumVal   = {accHi, accLo} + prodQ;
    sumHi    = sumVal[ACC_W-1:HALF_W];
    sumLo    = sumVal[HALF_W-1:0];
    sumNeg   = sumVal[ACC_W-1];
    overMax  = !sumNeg && (sumVal[ACC_W-1:HALF_W-1] != '0);
    underMin = sumNeg && (sumVal[ACC_W-1:HALF_W-1] != {TOP_W{1'b1}});
    resVal   = sumVal;
    if (satQ && !wordQ) begin
      resVal[ACC_W-1:HALF_W] = sumNeg ? (sumHi | HI_ONES) : (sumHi & HI_KEEP);
      resVal[HALF_W-1:0]     = sumLo;
    end else if (satQ && wordQ) begin
      if (underMin)     resVal = {W_HI, W_MIN};
      else if (overMax) resVal = {W_HI, W_MAX};
    end
  end

  // accumulator stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      accHi <= '0;
      accLo <= '0;
    end else if (strb.zeroAcc) begin
      accHi <= '0;
      accLo <= '0;
    end else if (strb.accum) begin
      accHi <= resVal[ACC_W-1:HALF_W];
      accLo <= resVal[HALF_W-1:0];
    end
  end

endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
  import mac_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int WORD_W = 16,
  parameter int LSAT_W = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HALF_W-1:0] opA,
  input  logic [HALF_W-1:0] opB,
  input  logic              wordMode,
  input  logic              satEn,
  input  logic              start,
  input  logic              clear,
  output logic [HALF_W-1:0] accHi,
  output logic [HALF_W-1:0] accLo,
  output logic              done
);

  mac_strobe_t strb;
  logic        ctrlBusy;

  mac_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .clear (clear),
    .strb  (strb),
    .busy  (ctrlBusy),
    .done  (done)
  );

  mac_datapath #(
    .HALF_W (HALF_W),
    .WORD_W (WORD_W),
    .LSAT_W (LSAT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .opA      (opA),
    .opB      (opB),
    .wordMode (wordMode),
    .satEn    (satEn),
    .accHi    (accHi),
    .accLo    (accLo)
  );

endmodule

// File: rtl/mac_sat_chk.sv
module mac_sat_chk #(
  parameter int HALF_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              clear,
  input logic              busy,
  input logic              done,
  input logic [HALF_W-1:0] accHi,
  input logic [HALF_W-1:0] accLo
);

  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (accHi == '0) && (accLo == '0));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_launch_no_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !clear) |=> ($stable(accHi) && $stable(accLo) && busy));

  p_done_after_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(busy) && !busy));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start && !clear) |=> ($stable(accHi) && $stable(accLo) && !busy));

endmodule

bind mac_sat_unit mac_sat_chk #(.HALF_W(HALF_W)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .clear (clear),
  .busy  (ctrlBusy),
  .done  (done),
  .accHi (accHi),
  .accLo (accLo)
);

// File: tb/sim_mac_sat_unit.sv
`timescale 1ns/1ps
module sim_mac_sat_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic        wordMode = 1'b0, satEn = 1'b0, start = 1'b0, clear = 1'b0;
  logic [31:0] accHi, accLo;
  logic        done;

  int   nChecks = 0;
  int   nFails  = 0;
  bit   finished = 0;
  logic [63:0] model = '0;

  always #5 clk = ~clk;

  mac_sat_unit u0 (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .wordMode(wordMode),
    .satEn(satEn), .start(start), .clear(clear),
    .accHi(accHi), .accLo(accLo), .done(done)
  );

  function automatic logic [63:0] refStep(logic [63:0] acc, logic [31:0] a,
                                          logic [31:0] b, bit w, bit s);
    longint p, sum;
    logic [31:0] hi;
    if (w) p = longint'(shortint'(a[15:0])) * longint'(shortint'(b[15:0]));
    else   p = longint'(int'(a)) * longint'(int'(b));
    sum = longint'(acc) + p;
    if (s && !w) begin
      hi = sum[63:32];
      if (sum < 0) hi = hi | 32'hFFFF0000;
      else         hi = hi & 32'h00007FFF;
      return {hi, sum[31:0]};
    end
    if (s && w) begin
      if (sum < -64'sd2147483648) return {32'd1, 32'h80000000};
      if (sum > 64'sd2147483647)  return {32'd1, 32'h7FFFFFFF};
    end
    return sum;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one full operation; checks total after update and the done pulse
  task automatic doOp(logic [31:0] a, logic [31:0] b, bit w, bit s, string req);
    @(negedge clk);
    opA = a; opB = b; wordMode = w; satEn = s; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk({req, " no write on launch edge R10"}, {accHi, accLo}, model);
    @(posedge clk);
    @(negedge clk);
    model = refStep(model, a, b, w, s);
    chk(req, {accHi, accLo}, model);
    chk("R10 done low before pulse", {63'd0, done}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R10 done pulse", {63'd0, done}, 64'd1);
  endtask

  task automatic doClear();
    @(negedge clk);
    clear = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clear = 1'b0;
    model = '0;
    chk("R9 clear when idle", {accHi, accLo}, 64'd0);
  endtask

  task automatic tReset();
    chk("R1 reset total", {accHi, accLo}, 64'd0);
    chk("R1 reset done", {63'd0, done}, 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 after release", {accHi, accLo, 31'd0, done}, 96'd0);
  endtask

  task automatic tLongPlain();
    doOp(32'd7, 32'd6, 0, 0, "R2 small");
    doOp(32'hFFFFFFFD, 32'd1000, 0, 0, "R2 negative operand");
    doOp(32'h80000000, 32'h80000000, 0, 0, "R2 max product");
    doOp(32'h7FFFFFFF, 32'h80000000, 0, 0, "R2 mixed sign");
    doClear();
  endtask

  task automatic tWordPlain();
    doOp(32'hABCD0005, 32'h1234FFFE, 1, 0, "R3 upper bits ignored");
    doOp(32'h00008000, 32'hFFFF8000, 1, 0, "R3 min by min");
    doOp(32'h55557FFF, 32'h00008000, 1, 0, "R3 mixed sign");
    doClear();
  endtask

  task automatic tLongSat();
    doOp(32'h80000000, 32'h7FFFFFFF, 0, 1, "R4 negative sum high bits set");
    chk("R4 upper half bits ones", {48'd0, accHi[31:16]}, 64'h0000_0000_0000_FFFF);
    doClear();
    doOp(32'h7FFFFFFF, 32'h7FFFFFFF, 0, 1, "R5 positive sum masked");
    chk("R5 high half value", {32'd0, accHi}, 64'h7FFF);
    doOp(32'd3, 32'd5, 0, 1, "R5 small positive");
    doClear();
  endtask

  task automatic tWordSat();
    doOp(32'h7FFF, 32'h7FFF, 1, 1, "R8 in range first");
    doOp(32'h7FFF, 32'h7FFF, 1, 1, "R8 in range second");
    doOp(32'h7FFF, 32'h7FFF, 1, 1, "R7 above max");
    chk("R7 clamp value", {accHi, accLo}, {32'd1, 32'h7FFFFFFF});
    doClear();
    doOp(32'h8000, 32'h7FFF, 1, 1, "R8 negative in range");
    doOp(32'h8000, 32'h7FFF, 1, 1, "R8 negative in range 2");
    doOp(32'h8000, 32'h7FFF, 1, 1, "R6 below min");
    chk("R6 clamp value", {accHi, accLo}, {32'd1, 32'h80000000});
    doClear();
    doOp(32'h8000, 32'h8000, 1, 1, "R8 exactly 2^30");
    doOp(32'h8000, 32'h8000, 1, 1, "R7 exactly 2^31 clamps");
    doClear();
  endtask

  task automatic tClearPriority();
    doOp(32'd100, 32'd100, 0, 0, "R2 preload");
    @(negedge clk);
    opA = 32'd9; opB = 32'd9; wordMode = 0; satEn = 0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    clear = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clear = 1'b0;
    model = '0;
    chk("R9 clear beats update", {accHi, accLo}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 done still pulses", {63'd0, done}, 64'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R9 total stays zero", {accHi, accLo}, 64'd0);
  endtask

  task automatic tStartIgnored();
    @(negedge clk);
    opA = 32'd11; opB = 32'd13; wordMode = 0; satEn = 0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    opA = 32'd1000; opB = 32'd1000;
    @(posedge clk);
    @(negedge clk);
    model = refStep(model, 32'd11, 32'd13, 0, 0);
    chk("R11 first update only", {accHi, accLo}, model);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R11 done once", {63'd0, done}, 64'd1);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R11 no second update", {accHi, accLo}, model);
      chk("R11 no second done", {63'd0, done}, 64'd0);
    end
    doClear();
  endtask

  task automatic tRandom();
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      bit w, s;
      a = $urandom();
      b = $urandom();
      w = $urandom_range(0, 1);
      s = $urandom_range(0, 1);
      if (w && ($urandom_range(0, 3) == 0)) begin
        a[15:0] = 16'h8000;
        b[15:0] = $urandom_range(0, 1) ? 16'h8000 : 16'h7FFF;
      end
      if (!w && s) doOp(a, b, w, s, model[63] ? "R4 random" : "R5 random");
      else if (w && s) doOp(a, b, w, s, "R6 R7 R8 random");
      else if (w) doOp(a, b, w, s, "R3 random");
      else doOp(a, b, w, s, "R2 random");
      if ($urandom_range(0, 40) == 0) doClear();
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    tReset();
    tLongPlain();
    tWordPlain();
    tLongSat();
    tWordSat();
    tClearPriority();
    tStartIgnored();
    tRandom();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule